// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block sits between the interrupt sources of a small multi-core cluster and the per-core CPU interfaces. Software programs it through a single 32-bit word-addressed register port: per-ID enable, software pending, trigger type, priority and target routing. Peripheral lines on IDs 32 and above are sampled as level or rising-edge sources. A dedicated write-only register raises software interrupts (IDs 0 to 15) towards a list of CPUs, and each raised interrupt remembers which CPU sent it.

For every CPU interface the block drives the set of IDs that are pending, enabled and routed to that CPU. It also drives the single best candidate: the lowest priority value wins, and the lowest ID breaks a tie. A global forwarding bit gates all of these outputs without disturbing the stored state. Each register access carries the number of the accessing CPU. That number selects the software-interrupt pending view and the read-only target bytes of the low IDs.

Top module: `idist_top`

Register map (byte addresses): control 0x000, type 0x004, software-interrupt trigger 0x008, enable set 0x100, enable clear 0x140, pending set 0x180, pending clear 0x1C0, priority 0x200, target 0x300, trigger config 0x400, software-interrupt pending set 0x500, software-interrupt pending clear 0x540. Within each array, word w covers the IDs starting at w×(IDs per word), and the lowest ID sits in the lowest bits.

## Requirements
- R1: After reset, control reads 0, all enables, pendings, priorities and targets of IDs 32 and up are 0, and no CPU output shows a pending ID or a valid candidate.
- R2: Enable words hold 32 IDs each. A 1 written to the set range enables the ID, a 1 written to the clear range disables it, and 0 bits have no effect. Reading either range returns the enable state. Only enabled IDs reach a CPU output.
- R3: Config words hold a 2-bit field per ID, 16 IDs per word. Bit 1 of the field selects rising-edge (1) or level (0), and bit 0 reads as 0. The fields of IDs 0 to 15 ignore writes and always read 2'b10.
- R4: An edge-configured line sets its pending bit only on a 0-to-1 transition. The bit stays set after the line falls, until software clears it. A clear while the line is held high stays cleared.
- R5: A level-configured line sets its pending bit in every cycle that it is high, and a software clear in such a cycle has no effect. After the line falls, the bit stays set until it is cleared.
- R6: Target words hold one byte per ID, four per word, lowest ID in bits 7:0, and bit c of a byte selects CPU c. Bytes of IDs 0 to 31 ignore writes and read as the one-hot mask of the accessing CPU. IDs 32 and up reach exactly the CPUs whose bits are set.
- R7: Priority words hold one byte per ID, four per word, and read back as written. Each CPU's candidate is the forwarded ID with the lowest priority value, and the lowest ID wins a tie. The candidate output is valid only when that CPU has a forwarded ID.
- R8: A write to 0x008 takes the ID from bits 3:0 and a CPU list from bits 23:16. For each existing CPU t whose bit is set, it marks the ID pending for t with the writing CPU as source. List bits of CPUs that do not exist are ignored.
- R9: The software-interrupt pending ranges hold one byte per ID (IDs 0 to 15), with bit s meaning source CPU s. Reads and writes act on the accessing CPU's view, and writing 1 sets or clears the source bit. An ID 0 to 15 is pending for a CPU while any source bit is set.
- R10: Bit 0 of control is the global forward enable. While it is 0, every CPU output shows no pending ID and no valid candidate, and the stored state is kept.
- R11: The type register is read-only, and its bits 4:0 read NUM_IDS/32-1.
- R12: Unmapped addresses and the trigger register read as 0. Writes to unmapped addresses change nothing.
- R13: The pending set and clear ranges act on IDs 16 and up. Bits for IDs 0 to 15 are ignored on write, and on read they show that ID's software-interrupt pending state for the accessing CPU.
- R14: Read data appears on the clock edge that samples the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Number of the accessing CPU |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | NUM_IDS-32 | Peripheral lines; bit k is ID 32+k |
| cpu_pend | output | NUM_CPUS*NUM_IDS | Forwarded IDs; bits c*NUM_IDS+i for CPU c |
| cpu_top_valid | output | NUM_CPUS | CPU c has a forwarded ID |
| cpu_top_id | output | NUM_CPUS*ID_W | Best candidate ID for each CPU |

## Verification
A corrupted enable, target or pending bit shows up on `cpu_pend` in the cycle after the write or line event that caused it. This is because the forwarding path is combinational from the state registers. A wrong priority byte or a wrong tie rule only changes `cpu_top_id`, so the bench builds cases with equal and unequal priorities on one CPU. Faults in the software-interrupt bank can hide behind the accessing-CPU view. For that reason, the checks read the bank from the sending CPU, from a target CPU and from an uninvolved CPU, and compare the per-CPU outputs as well.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam logic [11:0] A_CTRL    = 12'h000;
  localparam logic [11:0] A_TYPE    = 12'h004;
  localparam logic [11:0] A_SWI     = 12'h008;
  localparam logic [11:0] A_EN_SET  = 12'h100;
  localparam logic [11:0] A_EN_CLR  = 12'h140;
  localparam logic [11:0] A_PD_SET  = 12'h180;
  localparam logic [11:0] A_PD_CLR  = 12'h1C0;
  localparam logic [11:0] A_PRIO    = 12'h200;
  localparam logic [11:0] A_TGT     = 12'h300;
  localparam logic [11:0] A_CFG     = 12'h400;
  localparam logic [11:0] A_SGI_SET = 12'h500;
  localparam logic [11:0] A_SGI_CLR = 12'h540;

  // address of word w in an array starting at base
  function automatic logic [11:0] word_addr(input logic [11:0] base, input int w);
    return base + 12'(w * 4);
  endfunction

  // one-hot mask naming a CPU interface
  function automatic logic [7:0] cpu_onehot(input int c);
    return 8'(1) << c;
  endfunction

  // candidate beats current best only with a strictly lower value
  function automatic logic prio_beats(input logic [7:0] cand, input logic [7:0] best);
    return cand < best;
  endfunction
endpackage

// File: rtl/idist_sgi_bank.sv
module idist_sgi_bank #(
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   swi_fire,
  input  logic [3:0]             swi_id,
  input  logic [7:0]             swi_list,
  input  logic [CPU_W-1:0]       acc_cpu,
  input  logic                   set_we,
  input  logic                   clr_we,
  input  logic [1:0]             word_sel,
  input  logic [31:0]            wdata,
  output logic [NUM_CPUS*16-1:0] sgi_any,
  output logic [31:0]            view_word
);
  localparam int NSGI = 16;

  logic [NUM_CPUS-1:0] st_q [NUM_CPUS][NSGI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_CPUS; t++)
        for (int i = 0; i < NSGI; i++) st_q[t][i] <= '0;
    end else begin
      for (int t = 0; t < NUM_CPUS; t++) begin
        for (int i = 0; i < NSGI; i++) begin
          logic [NUM_CPUS-1:0] nxt;
          nxt = st_q[t][i];
          if (swi_fire && swi_list[t] && (int'(swi_id) == i))
            nxt[acc_cpu] = 1'b1;
          if (set_we && (int'(acc_cpu) == t) && (int'(word_sel) == i / 4))
            nxt = nxt | wdata[(i % 4) * 8 +: NUM_CPUS];
          if (clr_we && (int'(acc_cpu) == t) && (int'(word_sel) == i / 4))
            nxt = nxt & ~wdata[(i % 4) * 8 +: NUM_CPUS];
          st_q[t][i] <= nxt;
        end
      end
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_CPUS; t++)
      for (int i = 0; i < NSGI; i++) sgi_any[t * NSGI + i] = |st_q[t][i];
    for (int l = 0; l < 4; l++)
      view_word[l * 8 +: 8] = 8'(st_q[acc_cpu][int'(word_sel) * 4 + l]);
  end
endmodule

// File: rtl/idist_line_pend.sv
module idist_line_pend #(
  parameter int NUM_IDS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-33:0] lines,
  input  logic [NUM_IDS-33:0] line_edge,
  input  logic [NUM_IDS-1:0] sw_set,
  input  logic [NUM_IDS-1:0] sw_clr,
  output logic [NUM_IDS-1:0] hw_set,
  output logic [NUM_IDS-1:0] pend
);
  logic [NUM_IDS-33:0] lines_q;

  assign hw_set[31:0] = '0;
  for (genvar k = 0; k < NUM_IDS - 32; k++) begin : g_line
    assign hw_set[32 + k] = line_edge[k] ? (lines[k] & ~lines_q[k]) : lines[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      pend    <= '0;
    end else begin
      lines_q <= lines;
      pend    <= ((pend | sw_set) & ~sw_clr) | hw_set;
    end
  end
endmodule

// File: rtl/idist_cpu_route.sv
module idist_cpu_route #(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 6
) (
  input  logic                 fwd_en,
  input  logic [NUM_IDS-1:0]   enable,
  input  logic [NUM_IDS-1:0]   pend_in,
  input  logic [NUM_IDS-1:0]   tgt_hit,
  input  logic [NUM_IDS*8-1:0] prio_flat,
  output logic [NUM_IDS-1:0]   pend_out,
  output logic                 top_valid,
  output logic [ID_W-1:0]      top_id
);
  import idist_pkg::*;

  logic [7:0] best_prio;

  always_comb begin
    pend_out  = fwd_en ? (enable & pend_in & tgt_hit) : '0;
    top_valid = 1'b0;
    top_id    = '0;
    best_prio = 8'hFF;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (pend_out[i] && (!top_valid || prio_beats(prio_flat[i * 8 +: 8], best_prio))) begin
        top_valid = 1'b1;
        top_id    = ID_W'(i);
        best_prio = prio_flat[i * 8 +: 8];
      end
    end
  end
endmodule

// File: rtl/idist_top.sv
module idist_top #(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  parameter int ID_W     = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [11:0]               bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic [CPU_W-1:0]          bus_cpu,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_IDS-33:0]       irq_lines,
  output logic [NUM_CPUS*NUM_IDS-1:0] cpu_pend,
  output logic [NUM_CPUS-1:0]       cpu_top_valid,
  output logic [NUM_CPUS*ID_W-1:0]  cpu_top_id
);
  import idist_pkg::*;

  localparam int EN_WORDS  = NUM_IDS / 32;
  localparam int CFG_WORDS = NUM_IDS / 16;
  localparam int BY_WORDS  = NUM_IDS / 4;
  localparam logic [4:0] TYPE_N = 5'(NUM_IDS / 32 - 1);
  localparam logic [NUM_IDS-1:0] SW_PEND_OK = {{(NUM_IDS-16){1'b1}}, 16'h0};

  logic               ctrl_en;
  logic [NUM_IDS-1:0] enable_q;
  logic [NUM_IDS-1:0] cfg_edge_q;
  logic [7:0]         prio_q [NUM_IDS];
  logic [7:0]         tgt_q  [NUM_IDS];
  logic [NUM_IDS*8-1:0] prio_flat;

  // decoded write events, named for the checker
  logic [NUM_IDS-1:0] en_set_mask, en_clr_mask, pd_set_mask, pd_clr_mask;
  logic [NUM_IDS-1:0] line_hw_set, line_pend;
  logic               swi_fire, sgi_set_we, sgi_clr_we;
  logic [NUM_CPUS*16-1:0] sgi_any;
  logic [31:0]        sgi_view;
  logic [NUM_IDS-1:0] pend_view;
  logic [31:0]        rd_val;

  always_comb begin
    en_set_mask = '0;
    en_clr_mask = '0;
    pd_set_mask = '0;
    pd_clr_mask = '0;
    for (int w = 0; w < EN_WORDS; w++) begin
      if (bus_wr && bus_addr == word_addr(A_EN_SET, w)) en_set_mask[w * 32 +: 32] = bus_wdata;
      if (bus_wr && bus_addr == word_addr(A_EN_CLR, w)) en_clr_mask[w * 32 +: 32] = bus_wdata;
      if (bus_wr && bus_addr == word_addr(A_PD_SET, w)) pd_set_mask[w * 32 +: 32] = bus_wdata;
      if (bus_wr && bus_addr == word_addr(A_PD_CLR, w)) pd_clr_mask[w * 32 +: 32] = bus_wdata;
    end
    pd_set_mask = pd_set_mask & SW_PEND_OK;
    pd_clr_mask = pd_clr_mask & SW_PEND_OK;
  end

  assign swi_fire   = bus_wr && (bus_addr == A_SWI);
  assign sgi_set_we = bus_wr && (bus_addr[11:4] == A_SGI_SET[11:4]);
  assign sgi_clr_we = bus_wr && (bus_addr[11:4] == A_SGI_CLR[11:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      enable_q   <= '0;
      cfg_edge_q <= {{(NUM_IDS-16){1'b0}}, 16'hFFFF};
      for (int i = 0; i < NUM_IDS; i++) begin
        prio_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_en <= bus_wdata[0];
      enable_q <= (enable_q | en_set_mask) & ~en_clr_mask;
      for (int w = 0; w < BY_WORDS; w++) begin
        if (bus_wr && bus_addr == word_addr(A_PRIO, w))
          for (int b = 0; b < 4; b++) prio_q[w * 4 + b] <= bus_wdata[b * 8 +: 8];
        if (w >= 8 && bus_wr && bus_addr == word_addr(A_TGT, w))
          for (int b = 0; b < 4; b++) tgt_q[w * 4 + b] <= bus_wdata[b * 8 +: 8];
      end
      for (int w = 1; w < CFG_WORDS; w++) begin
        if (bus_wr && bus_addr == word_addr(A_CFG, w))
          for (int b = 0; b < 16; b++) cfg_edge_q[w * 16 + b] <= bus_wdata[b * 2 + 1];
      end
    end
  end

  idist_sgi_bank #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_sgi (
    .clk(clk), .rst_n(rst_n),
    .swi_fire(swi_fire), .swi_id(bus_wdata[3:0]), .swi_list(bus_wdata[23:16]),
    .acc_cpu(bus_cpu), .set_we(sgi_set_we), .clr_we(sgi_clr_we),
    .word_sel(bus_addr[3:2]), .wdata(bus_wdata),
    .sgi_any(sgi_any), .view_word(sgi_view)
  );

  idist_line_pend #(.NUM_IDS(NUM_IDS)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .lines(irq_lines), .line_edge(cfg_edge_q[NUM_IDS-1:32]),
    .sw_set(pd_set_mask), .sw_clr(pd_clr_mask),
    .hw_set(line_hw_set), .pend(line_pend)
  );

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) prio_flat[i * 8 +: 8] = prio_q[i];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_IDS-1:0] view;
    logic [NUM_IDS-1:0] hit;
    always_comb begin
      for (int i = 0; i < NUM_IDS; i++) begin
        view[i] = (i < 16) ? sgi_any[c * 16 + (i % 16)] : line_pend[i];
        hit[i]  = (i < 32) ? 1'b1 : tgt_q[i][c];
      end
    end
    idist_cpu_route #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_route (
      .fwd_en(ctrl_en), .enable(enable_q), .pend_in(view), .tgt_hit(hit),
      .prio_flat(prio_flat),
      .pend_out(cpu_pend[c * NUM_IDS +: NUM_IDS]),
      .top_valid(cpu_top_valid[c]),
      .top_id(cpu_top_id[c * ID_W +: ID_W])
    );
  end

  assign pend_view = {line_pend[NUM_IDS-1:16], sgi_any[int'(bus_cpu) * 16 +: 16]};

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_CTRL) rd_val = {31'b0, ctrl_en};
    if (bus_addr == A_TYPE) rd_val = {27'b0, TYPE_N};
    for (int w = 0; w < EN_WORDS; w++) begin
      if (bus_addr == word_addr(A_EN_SET, w) || bus_addr == word_addr(A_EN_CLR, w))
        rd_val = enable_q[w * 32 +: 32];
      if (bus_addr == word_addr(A_PD_SET, w) || bus_addr == word_addr(A_PD_CLR, w))
        rd_val = pend_view[w * 32 +: 32];
    end
    for (int w = 0; w < BY_WORDS; w++) begin
      if (bus_addr == word_addr(A_PRIO, w))
        for (int b = 0; b < 4; b++) rd_val[b * 8 +: 8] = prio_q[w * 4 + b];
      if (bus_addr == word_addr(A_TGT, w))
        for (int b = 0; b < 4; b++)
          rd_val[b * 8 +: 8] = (w < 8) ? cpu_onehot(int'(bus_cpu)) : tgt_q[w * 4 + b];
    end
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (bus_addr == word_addr(A_CFG, w))
        for (int b = 0; b < 16; b++) rd_val[b * 2 +: 2] = {cfg_edge_q[w * 16 + b], 1'b0};
    end
    if (bus_addr[11:4] == A_SGI_SET[11:4] || bus_addr[11:4] == A_SGI_CLR[11:4])
      rd_val = sgi_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/idist_chk.sv
module idist_chk #(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 4,
  parameter int ID_W     = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ctrl_en,
  input logic [NUM_CPUS*NUM_IDS-1:0] cpu_pend,
  input logic [NUM_CPUS-1:0]         cpu_top_valid,
  input logic [NUM_CPUS*ID_W-1:0]    cpu_top_id,
  input logic [NUM_IDS-1:0]          line_hw_set,
  input logic [NUM_IDS-1:0]          line_pend,
  input logic [NUM_IDS-1:0]          en_clr_mask,
  input logic [NUM_IDS-1:0]          enable_q
);
  // R10
  fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (cpu_pend == '0 && cpu_top_valid == '0));

  // R4
  hw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_hw_set) |=> ((line_pend & $past(line_hw_set)) == $past(line_hw_set)));

  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr_mask) |=> ((enable_q & $past(en_clr_mask)) == '0));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    // R7
    top_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_top_valid[c] |-> cpu_pend[c * NUM_IDS + int'(cpu_top_id[c * ID_W +: ID_W])]);
    // R7
    top_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_pend[c * NUM_IDS +: NUM_IDS] == '0) |-> !cpu_top_valid[c]);
  end
endmodule

bind idist_top idist_chk #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cpu_pend(cpu_pend),
  .cpu_top_valid(cpu_top_valid), .cpu_top_id(cpu_top_id),
  .line_hw_set(line_hw_set), .line_pend(line_pend),
  .en_clr_mask(en_clr_mask), .enable_q(enable_q)
);

// File: tb/tb_idist_top.sv
module tb_idist_top;
  localparam int NI = 64;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [CW-1:0] bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NI-33:0] irq_lines = '0;
  logic [NC*NI-1:0] cpu_pend;
  logic [NC-1:0] cpu_top_valid;
  logic [NC*IW-1:0] cpu_top_id;

  int errors = 0, checks = 0;
  logic rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic done = 1'b0;

  always #10 clk = ~clk;

  idist_top #(.NUM_IDS(NI), .NUM_CPUS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .irq_lines(irq_lines), .cpu_pend(cpu_pend),
    .cpu_top_valid(cpu_top_valid), .cpu_top_id(cpu_top_id)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one read result per sampled read
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R14 actual=%h expected=<none>", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int c = 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = CW'(c);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input int c, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_cpu = CW'(c);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [63:0] pend_of(input int c);
    return cpu_pend[c * NI +: NI];
  endfunction

  function automatic logic [63:0] top_of(input int c);
    return {57'b0, cpu_top_valid[c], cpu_top_id[c * IW +: IW]};
  endfunction

  // valid bit in bit 6, id below
  function automatic logic [63:0] top_exp(input int id);
    return 64'h40 | 64'(id);
  endfunction

  task automatic line_set(input int k, input logic v);
    @(negedge clk);
    irq_lines[k] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu_pend", 64'(cpu_pend), 64'h0);
    chk("R1 top_valid", 64'(cpu_top_valid), 64'h0);
    rd(12'h000, 0, 32'h0, "R1 ctrl");
    rd(12'h220, 0, 32'h0, "R1 prio");
    // R11 type, R14 timing
    rd(12'h004, 0, 32'h1, "R11 R14 type");
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 0, 32'h1, "R11 read-only");
    // R12 unmapped
    wr(12'h0F0, 32'h1);
    rd(12'h0F0, 0, 32'h0, "R12 unmapped");
    rd(12'h008, 0, 32'h0, "R12 trigger reads 0");
    rd(12'h000, 0, 32'h0, "R12 ctrl untouched");
    // R2 enables
    wr(12'h104, 32'h5);
    rd(12'h144, 0, 32'h5, "R2 clear range reads state");
    wr(12'h144, 32'h1);
    rd(12'h104, 0, 32'h4, "R2 clear");
    wr(12'h104, 32'h0);
    rd(12'h104, 0, 32'h4, "R2 zero no effect");
    wr(12'h104, 32'hF);
    // R3 config
    wr(12'h408, 32'hC);
    rd(12'h408, 0, 32'h8, "R3 edge bit");
    wr(12'h400, 32'h0);
    rd(12'h400, 0, 32'hAAAA_AAAA, "R3 low ids fixed");
    // R6 targets
    wr(12'h320, 32'h010C_0201);
    rd(12'h320, 0, 32'h010C_0201, "R6 target rw");
    wr(12'h300, 32'hFFFF_FFFF, 2);
    rd(12'h300, 2, 32'h0404_0404, "R6 low ids one-hot");
    // R7 priority
    wr(12'h220, 32'h1020_3040);
    rd(12'h220, 0, 32'h1020_3040, "R7 prio rw");
    wr(12'h000, 32'h1);
    // R5 level id32 -> cpu0
    line_set(0, 1'b1);
    chk("R5 level pend", pend_of(0), 64'h1 << 32);
    chk("R6 not on cpu1", pend_of(1), 64'h0);
    chk("R7 single top", top_of(0), top_exp(32));
    wr(12'h1C4, 32'h1);
    chk("R5 clear while high", pend_of(0), 64'h1 << 32);
    line_set(0, 1'b0);
    chk("R5 latched after fall", pend_of(0), 64'h1 << 32);
    wr(12'h1C4, 32'h1);
    chk("R5 cleared", pend_of(0), 64'h0);
    chk("R7 no top", top_of(0), 64'h0);
    // R4 edge id33 -> cpu1
    line_set(1, 1'b1);
    chk("R4 edge pend", pend_of(1), 64'h1 << 33);
    wr(12'h1C4, 32'h2);
    @(negedge clk); @(negedge clk);
    chk("R4 held high stays clear", pend_of(1), 64'h0);
    line_set(1, 1'b0);
    chk("R4 fall no set", pend_of(1), 64'h0);
    line_set(1, 1'b1);
    chk("R4 second edge", pend_of(1), 64'h1 << 33);
    line_set(1, 1'b0);
    wr(12'h1C4, 32'h2);
    // R13 software pending, R7 selection, R6 multi-target
    wr(12'h184, 32'hD);
    rd(12'h184, 0, 32'hD, "R13 pend read");
    chk("R6 cpu0 set", pend_of(0), (64'h1 << 32) | (64'h1 << 35));
    chk("R7 cpu0 lowest value", top_of(0), top_exp(35));
    chk("R6 cpu2 top", top_of(2), top_exp(34));
    chk("R6 cpu3 top", top_of(3), top_exp(34));
    chk("R7 cpu1 none", top_of(1), 64'h0);
    wr(12'h220, 32'h4020_3040);
    chk("R7 tie lowest id", top_of(0), top_exp(32));
    // R10 global enable
    wr(12'h000, 32'h0);
    chk("R10 gated pend", 64'(cpu_pend), 64'h0);
    chk("R10 gated top", 64'(cpu_top_valid), 64'h0);
    rd(12'h184, 0, 32'hD, "R10 state kept");
    wr(12'h000, 32'h1);
    chk("R10 restored", pend_of(0), (64'h1 << 32) | (64'h1 << 35));
    wr(12'h1C4, 32'hF);
    chk("R13 cleared", pend_of(0), 64'h0);
    wr(12'h180, 32'h0001_FFFF);
    rd(12'h180, 0, 32'h0001_0000, "R13 low ids ignored");
    wr(12'h1C0, 32'h0001_0000);
    rd(12'h180, 0, 32'h0, "R13 clear id16");
    // R8 software trigger from cpu1 to cpu0,cpu2 (+ absent cpus)
    wr(12'h100, 32'h8);
    wr(12'h008, 32'h00F5_0003, 1);
    chk("R8 cpu0", pend_of(0), 64'h8);
    chk("R8 cpu2", pend_of(2), 64'h8);
    chk("R8 cpu1 untouched", pend_of(1), 64'h0);
    chk("R8 cpu3 untouched", pend_of(3), 64'h0);
    chk("R7 cpu0 sgi top", top_of(0), top_exp(3));
    rd(12'h500, 0, 32'h0200_0000, "R9 source byte");
    rd(12'h180, 0, 32'h8, "R13 sgi view");
    rd(12'h500, 3, 32'h0, "R9 other view");
    // R9 clear / set
    wr(12'h540, 32'h0200_0000, 0);
    chk("R9 cpu0 cleared", pend_of(0), 64'h0);
    chk("R9 cpu2 kept", pend_of(2), 64'h8);
    wr(12'h500, 32'h0000_0300, 3);
    chk("R2 disabled not forwarded", pend_of(3), 64'h0);
    rd(12'h500, 3, 32'h0000_0300, "R9 set readback");
    wr(12'h100, 32'h2);
    chk("R9 cpu3 id1", pend_of(3), 64'h2);
    rd(12'h100, 0, 32'hA, "R2 word0");
    repeat (3) @(negedge clk);
    chk("R14 all reads seen", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule